// File: doc/BRIEF.md
# Board Address Region Decoder

This block sorts every bus address issued by the local processor into one of four destinations: the on-board RAM, the on-board ROM, the peripherals inside the I/O block, or the system bus. Each on-board region has an 8-bit base value that is matched against address bits 23..16. Size options decide which of those bits take part in the match and whether bit 15 also qualifies it. The I/O block is always 64K. Only its top 512 bytes reach local peripherals. The rest of the I/O block, and every address that hits no local region, is sent to the system bus.

A second decoder watches addresses driven by other bus masters. It raises a window select when such an address falls inside the externally visible part of the local RAM. That window is 32K, 64K or 128K and has a base of its own. The window select is held low while the board itself is running a system-bus cycle, so the board cannot reach its own memory through the bus.

A two-state controller captures the board-side decode when the address strobe is first seen high. It holds that decode for as long as the strobe stays high. Holding the decode is what lets the window inhibit follow the board's own bus cycle. The states are ST_IDLE and ST_BUSY. ST_IDLE goes to ST_BUSY (capture) when the strobe is high. ST_BUSY stays in ST_BUSY (hold) while the strobe remains high. ST_BUSY returns to ST_IDLE (release) when the strobe falls.

Top module: `addr_region_decoder`

## Requirements
- R1: While reset is asserted, and on the first edge after it, every select output is 0.
- R2: When ram_size_128k is 0, the RAM select needs address bits 23..16 equal to ram_base and bit 15 equal to 0. With bit 15 equal to 1, the RAM is not selected.
- R3: When ram_size_128k is 1, bit 15 is not examined and bit 0 of ram_base is ignored. Address bits 23..17 are matched against ram_base bits 7..1, which gives a 128K block.
- R4: rom_size selects the ROM block size. With 0 the block is 64K and all eight bits are matched. With 1 the block is 128K and address bit 16 is not matched. With 2 or 3 the block is 256K and address bits 17..16 are not matched.
- R5: When address bits 23..16 equal io_base, addresses with bits 15..9 all ones raise the I/O select. Every other address in that 64K block raises the off-board select.
- R6: An address that selects no local RAM, ROM or local I/O raises the off-board select. During a captured cycle exactly one of the four board selects is high.
- R7: When local regions overlap, RAM wins over ROM and ROM wins over I/O.
- R8: The board selects go high on the clock edge after the strobe is sampled high in ST_IDLE. They then keep their value, ignoring any address change, while the strobe stays high. They clear on the edge where the strobe is sampled low. With no strobe, no select is raised.
- R9: The window select rises one edge after ext_as is sampled high with a matching external address. xwin_size 0 gives a 32K window (bit 15 must be 0 and all eight base bits are matched). xwin_size 1 gives a 64K window. xwin_size 2 or 3 gives a 128K window, where bit 0 of xwin_base is ignored.
- R10: The window select stays low on any edge where the board's off-board select is captured or held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr_hi | input | 15 | Board address bits 23..9 |
| cpu_as | input | 1 | Board address strobe, active high |
| ram_base | input | 8 | RAM base, matched against bits 23..16 |
| rom_base | input | 8 | ROM base |
| io_base | input | 8 | I/O block base |
| xwin_base | input | 8 | External window base |
| ram_size_128k | input | 1 | 0 selects the 32K RAM option, 1 selects the 128K option |
| rom_size | input | 2 | ROM block size code |
| xwin_size | input | 2 | External window size code |
| ext_addr_hi | input | 9 | External master address bits 23..15 |
| ext_as | input | 1 | External master strobe, active high |
| sel_ram | output | 1 | Local RAM select |
| sel_rom | output | 1 | Local ROM select |
| sel_io | output | 1 | Local peripheral select |
| sel_offboard | output | 1 | System-bus access select |
| sel_xwin | output | 1 | External-master window select |

## Verification
The bench builds the block with its default parameters: a 24-bit address, 8-bit bases and a 512-byte local peripheral area. This means the I/O local boundary falls at bit 9 and the half-block qualifier falls at bit 15. With these values every size code can be reached, both RAM options can be used, and the three local regions can be made to overlap by setting the bases equal. The bench also runs off-board and RAM cycles while an external master presents a matching window address, which exercises the inhibit in both directions.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
    typedef enum logic {ST_IDLE, ST_BUSY} dec_state_t;

    typedef struct packed {
        logic ram;
        logic rom;
        logic io;
        logic off;
    } board_sel_t;
endpackage

// File: rtl/adr_cmp.sv
module adr_cmp #(
    parameter int BW = 8
) (
    input  logic [BW-1:0] addr_hi,
    input  logic [BW-1:0] base,
    input  logic [BW-1:0] care,
    output logic          hit
);
    assign hit = ((addr_hi ^ base) & care) == '0;
endmodule

// File: rtl/local_decode.sv
module local_decode
    import addr_dec_pkg::*;
#(
    parameter int AW             = 24,
    parameter int BW             = 8,
    parameter int IO_LOCAL_BYTES = 512
) (
    input  logic [AW-1:$clog2(IO_LOCAL_BYTES)] addr_hi,
    input  logic [BW-1:0]                      ram_base,
    input  logic [BW-1:0]                      rom_base,
    input  logic [BW-1:0]                      io_base,
    input  logic                               ram_big,
    input  logic [1:0]                         rom_size,
    output board_sel_t                         sel
);
    localparam int HI_LSB  = AW - BW;
    localparam int LOC_LSB = $clog2(IO_LOCAL_BYTES);
    localparam logic [BW-1:0] ALL = '1;

    logic [BW-1:0] ram_care, rom_care;
    logic          ram_cmp, rom_cmp, io_cmp;
    logic          ram_hit, io_local;

    always_comb begin
        ram_care = ram_big ? (ALL << 1) : ALL;
        unique case (rom_size)
            2'd0:    rom_care = ALL;
            2'd1:    rom_care = ALL << 1;
            default: rom_care = ALL << 2;
        endcase
    end

    adr_cmp #(.BW(BW)) u_ram (.addr_hi(addr_hi[AW-1:HI_LSB]), .base(ram_base),
                              .care(ram_care), .hit(ram_cmp));
    adr_cmp #(.BW(BW)) u_rom (.addr_hi(addr_hi[AW-1:HI_LSB]), .base(rom_base),
                              .care(rom_care), .hit(rom_cmp));
    adr_cmp #(.BW(BW)) u_io  (.addr_hi(addr_hi[AW-1:HI_LSB]), .base(io_base),
                              .care(ALL), .hit(io_cmp));

    assign ram_hit  = ram_cmp & (ram_big | ~addr_hi[HI_LSB-1]);
    assign io_local = io_cmp & (&addr_hi[HI_LSB-1:LOC_LSB]);

    always_comb begin
        sel = '0;
        if (ram_hit)       sel.ram = 1'b1;
        else if (rom_cmp)  sel.rom = 1'b1;
        else if (io_local) sel.io  = 1'b1;
        else               sel.off = 1'b1;
    end
endmodule

// File: rtl/xwin_decode.sv
module xwin_decode #(
    parameter int AW = 24,
    parameter int BW = 8
) (
    input  logic [AW-1:AW-BW-1] addr_hi,
    input  logic [BW-1:0]       base,
    input  logic [1:0]          size,
    output logic                hit
);
    localparam int HI_LSB = AW - BW;
    localparam logic [BW-1:0] ALL = '1;

    logic [BW-1:0] care;
    logic          cmp;

    always_comb begin
        unique case (size)
            2'd0, 2'd1: care = ALL;
            default:    care = ALL << 1;
        endcase
    end

    adr_cmp #(.BW(BW)) u_cmp (.addr_hi(addr_hi[AW-1:HI_LSB]), .base(base),
                              .care(care), .hit(cmp));

    assign hit = cmp & ((size != 2'd0) | ~addr_hi[HI_LSB-1]);
endmodule

// File: rtl/addr_region_decoder.sv
module addr_region_decoder
    import addr_dec_pkg::*;
#(
    parameter int AW             = 24,
    parameter int BW             = 8,
    parameter int IO_LOCAL_BYTES = 512
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [AW-1:$clog2(IO_LOCAL_BYTES)] cpu_addr_hi,
    input  logic                               cpu_as,
    input  logic [BW-1:0]                      ram_base,
    input  logic [BW-1:0]                      rom_base,
    input  logic [BW-1:0]                      io_base,
    input  logic [BW-1:0]                      xwin_base,
    input  logic                               ram_size_128k,
    input  logic [1:0]                         rom_size,
    input  logic [1:0]                         xwin_size,
    input  logic [AW-1:AW-BW-1]                ext_addr_hi,
    input  logic                               ext_as,
    output logic                               sel_ram,
    output logic                               sel_rom,
    output logic                               sel_io,
    output logic                               sel_offboard,
    output logic                               sel_xwin
);
    dec_state_t state_q, state_d;
    board_sel_t dec_sel, sel_q, sel_d;
    logic       xhit, xwin_d, xwin_q;

    local_decode #(.AW(AW), .BW(BW), .IO_LOCAL_BYTES(IO_LOCAL_BYTES)) u_loc (
        .addr_hi (cpu_addr_hi),
        .ram_base(ram_base),
        .rom_base(rom_base),
        .io_base (io_base),
        .ram_big (ram_size_128k),
        .rom_size(rom_size),
        .sel     (dec_sel)
    );

    xwin_decode #(.AW(AW), .BW(BW)) u_xwin (
        .addr_hi(ext_addr_hi),
        .base   (xwin_base),
        .size   (xwin_size),
        .hit    (xhit)
    );

    always_comb begin
        state_d = state_q;
        sel_d   = '0;
        unique case (state_q)
            ST_IDLE: if (cpu_as) begin
                state_d = ST_BUSY;
                sel_d   = dec_sel;
            end
            ST_BUSY: if (cpu_as) sel_d = sel_q;
                     else        state_d = ST_IDLE;
        endcase
        xwin_d = ext_as & xhit & ~sel_d.off;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            xwin_q <= 1'b0;
        end else begin
            sel_q  <= sel_d;
            xwin_q <= xwin_d;
        end
    end

    assign sel_ram      = sel_q.ram;
    assign sel_rom      = sel_q.rom;
    assign sel_io       = sel_q.io;
    assign sel_offboard = sel_q.off;
    assign sel_xwin     = xwin_q;
endmodule

// File: rtl/addr_region_decoder_chk.sv
module addr_region_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_as,
    input logic ext_as,
    input logic sel_ram,
    input logic sel_rom,
    input logic sel_io,
    input logic sel_offboard,
    input logic sel_xwin
);
    logic [3:0] bsel;
    assign bsel = {sel_ram, sel_rom, sel_io, sel_offboard};

    AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(bsel)); // R7
    AST_NO_STROBE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n) !$past(cpu_as) |-> bsel == 4'b0000); // R8
    AST_ONE_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) ($past(cpu_as) && $past(rst_n)) |-> $countones(bsel) == 1); // R6
    AST_HOLD_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) (cpu_as && bsel != 4'b0000) |=> $stable(bsel)); // R8
    AST_XWIN_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n) sel_xwin |-> !sel_offboard); // R10
    AST_XWIN_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) sel_xwin |-> $past(ext_as)); // R9
endmodule

bind addr_region_decoder addr_region_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_as(cpu_as), .ext_as(ext_as),
    .sel_ram(sel_ram), .sel_rom(sel_rom), .sel_io(sel_io),
    .sel_offboard(sel_offboard), .sel_xwin(sel_xwin)
);

// File: tb/tb_addr_region_decoder.sv
module tb_addr_region_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic        cpu_as = 1'b0;
    logic [7:0]  ram_base = 8'h00, rom_base = 8'hFE, io_base = 8'hFF, xwin_base = 8'h40;
    logic        ram_size_128k = 1'b0;
    logic [1:0]  rom_size = 2'd0, xwin_size = 2'd0;
    logic [23:0] ext_addr = '0;
    logic        ext_as = 1'b0;
    logic        sel_ram, sel_rom, sel_io, sel_offboard, sel_xwin;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [4:0] E_NONE = 5'b00000, E_RAM = 5'b10000, E_ROM = 5'b01000,
                           E_IO = 5'b00100, E_OFF = 5'b00010, E_XW = 5'b00001;

    always #2 clk = ~clk;

    addr_region_decoder dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr_hi(cpu_addr[23:9]), .cpu_as(cpu_as),
        .ram_base(ram_base), .rom_base(rom_base), .io_base(io_base), .xwin_base(xwin_base),
        .ram_size_128k(ram_size_128k), .rom_size(rom_size), .xwin_size(xwin_size),
        .ext_addr_hi(ext_addr[23:15]), .ext_as(ext_as),
        .sel_ram(sel_ram), .sel_rom(sel_rom), .sel_io(sel_io),
        .sel_offboard(sel_offboard), .sel_xwin(sel_xwin)
    );

    task automatic check(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {sel_ram, sel_rom, sel_io, sel_offboard, sel_xwin};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: selects %b expected %b", req, act, exp);
        end
    endtask

    task automatic board_cycle(input string req, input logic [23:0] a, input logic [4:0] exp);
        cpu_addr = a; cpu_as = 1'b1;
        @(negedge clk); check(req, exp);
        cpu_as = 1'b0;
        @(negedge clk); check(req, E_NONE);
    endtask

    task automatic t_reset();
        check("R1", E_NONE);
        rst_n = 1'b1; @(negedge clk); check("R1", E_NONE);
    endtask

    task automatic t_ram32();
        board_cycle("R2", 24'h001234, E_RAM);
        board_cycle("R2", 24'h009000, E_OFF);
    endtask

    task automatic t_ram128();
        ram_size_128k = 1'b1; ram_base = 8'h21;
        board_cycle("R3", 24'h200000, E_RAM);
        board_cycle("R3", 24'h21FFFF, E_RAM);
        board_cycle("R3", 24'h220000, E_OFF);
        ram_size_128k = 1'b0; ram_base = 8'h00;
    endtask

    task automatic t_rom();
        board_cycle("R4", 24'hFE0100, E_ROM);
        rom_base = 8'hA5; rom_size = 2'd0;
        board_cycle("R4", 24'hA40000, E_OFF);
        rom_size = 2'd1;
        board_cycle("R4", 24'hA40000, E_ROM);
        board_cycle("R4", 24'hA60000, E_OFF);
        rom_size = 2'd2;
        board_cycle("R4", 24'hA70000, E_ROM);
        board_cycle("R4", 24'hA80000, E_OFF);
        rom_size = 2'd3;
        board_cycle("R4", 24'hA6FFFF, E_ROM);
        rom_size = 2'd0; rom_base = 8'hFE;
    endtask

    task automatic t_io();
        board_cycle("R5", 24'hFFFE00, E_IO);
        board_cycle("R5", 24'hFFFFFF, E_IO);
        board_cycle("R5", 24'hFFFDFF, E_OFF);
        board_cycle("R5", 24'hFF0000, E_OFF);
    endtask

    task automatic t_default();
        board_cycle("R6", 24'h123456, E_OFF);
        board_cycle("R6", 24'h7F0000, E_OFF);
    endtask

    task automatic t_priority();
        ram_base = 8'h30; rom_base = 8'h30; io_base = 8'h30;
        board_cycle("R7", 24'h300000, E_RAM);
        board_cycle("R7", 24'h30FE00, E_ROM);
        rom_base = 8'hFE;
        board_cycle("R7", 24'h30FE00, E_IO);
        ram_base = 8'h00; io_base = 8'hFF;
    endtask

    task automatic t_timing();
        @(negedge clk); check("R8", E_NONE);
        cpu_addr = 24'h000010; cpu_as = 1'b1;
        @(negedge clk); check("R8", E_RAM);
        cpu_addr = 24'hFFFE00;
        @(negedge clk); check("R8", E_RAM);
        @(negedge clk); check("R8", E_RAM);
        cpu_as = 1'b0;
        @(negedge clk); check("R8", E_NONE);
    endtask

    task automatic xw(input string req, input logic [23:0] a, input logic exp);
        ext_addr = a; ext_as = 1'b1;
        @(negedge clk); check(req, exp ? E_XW : E_NONE);
        ext_as = 1'b0;
        @(negedge clk); check(req, E_NONE);
    endtask

    task automatic t_xwin();
        xwin_base = 8'h40; xwin_size = 2'd0;
        xw("R9", 24'h401000, 1'b1);
        xw("R9", 24'h408000, 1'b0);
        xwin_size = 2'd1;
        xw("R9", 24'h408000, 1'b1);
        xw("R9", 24'h410000, 1'b0);
        xwin_size = 2'd2; xwin_base = 8'h41;
        xw("R9", 24'h400000, 1'b1);
        xw("R9", 24'h41F000, 1'b1);
        xwin_size = 2'd3;
        xw("R9", 24'h420000, 1'b0);
        xwin_size = 2'd0; xwin_base = 8'h40;
    endtask

    task automatic t_inhibit();
        ext_addr = 24'h401000; ext_as = 1'b1;
        cpu_addr = 24'h123456; cpu_as = 1'b1;
        @(negedge clk); check("R10", E_OFF);
        @(negedge clk); check("R10", E_OFF);
        cpu_as = 1'b0;
        @(negedge clk); check("R10", E_XW);
        cpu_addr = 24'h000100; cpu_as = 1'b1;
        @(negedge clk); check("R10", E_RAM | E_XW);
        cpu_as = 1'b0; ext_as = 1'b0;
        @(negedge clk); check("R10", E_NONE);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                t_ram32();
                t_ram128();
                t_rom();
                t_io();
                t_default();
                t_priority();
                t_timing();
                t_xwin();
                t_inhibit();
            end
            begin
                repeat (20000) @(negedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule